// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken and turns that guess into a predicted next program counter. It keeps a short shift register of the most recent resolved branch outcomes across the whole program. That history value picks one of several banks of 2-bit saturating counters. Low bits of the branch address, above the instruction-alignment bits, pick the counter within that bank.

A decode stage presents the branch address and its computed target on the lookup port. It receives the target when the chosen counter leans taken, and the fall-through address (branch address plus 4) otherwise. An execute stage reports every resolved branch on the update port, whether or not it was mispredicted. Each report trains the counter in the bank chosen by the history as it stands, and then shifts the outcome into the history. All state lives in flip-flops. The lookup is a combinational read of the current state.

Top module: `bp2l_predictor`

## Requirements
- R1: After reset the history is 00 and every counter holds 01 (weak not-taken), so every lookup predicts not-taken and returns the branch address plus 4.
- R2: A lookup predicts taken exactly when the selected counter's upper bit is 1. In that case the next PC is the lookup target; otherwise it is the lookup address plus 4.
- R3: The counter index is the branch address bits [IDX_W+1:2]. Address bits [1:0] and all bits above the index have no effect on which counter is used.
- R4: A taken update moves the counter up by one: 00→01→10→11. A taken update at 11 leaves it at 11.
- R5: A not-taken update moves the counter down by one. A not-taken update at 00 leaves it at 00.
- R6: A counter at 11 that sees one not-taken outcome still predicts taken. A counter at 00 that sees one taken outcome still predicts not-taken.
- R7: Each valid update shifts its outcome into the history. The newest outcome goes in bit 0, the previous one moves to bit 1, and taken is 1. The history value, read as an unsigned number, is the bank used by lookups.
- R8: An update trains only the counter in the bank selected by the history before that update's own shift.
- R9: While the update valid input is low, the counters and the history do not change, whatever the other update inputs carry.
- R10: A lookup in the same cycle as an update returns the prediction from the state before that update, even when both address the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| lk_pc | input | ADDR_W | Address of the branch being predicted |
| lk_target | input | ADDR_W | Computed taken-target of that branch |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_next_pc | output | ADDR_W | Predicted next PC |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench drives hundreds of pseudo-random updates. After each one it sweeps every counter of the bank that the current history selects. The address bits outside the index are randomised, so a design that decoded the wrong address bits, or picked the bank from the history after the shift, would mismatch almost at once. Directed runs push one counter past both saturation ends, where a wrapping counter would flip its prediction. They also step a saturated counter back by one, where a design without hysteresis would flip after a single wrong outcome. Other runs hold the update valid input low while noise sits on the other update inputs. Before every update edge the bench looks up all entries, so a design that forwarded the new counter value would show up there.

// File: rtl/bp2l_pkg.sv
package bp2l_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_NT = 2'b00;
  localparam ctr2_t CTR_WEAK_NT   = 2'b01;
  localparam ctr2_t CTR_WEAK_T    = 2'b10;
  localparam ctr2_t CTR_STRONG_T  = 2'b11;

  // Saturating step: up on taken, down on not-taken.
  function automatic ctr2_t ctr_step(ctr2_t cur, logic taken);
    ctr2_t res;
    res = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) res = cur + 2'd1;
    end else begin
      if (cur != CTR_STRONG_NT) res = cur - 2'd1;
    end
    return res;
  endfunction

  function automatic logic ctr_dir(ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp2l_rst_sync.sv
module bp2l_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bp2l_ghist.sv
module bp2l_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HIST_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;

  // R9: no shift request, history keeps its value
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

  // R7: the newest outcome lands in bit 0
  a_r7_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(bit_in));

  // R7: the old bit 0 moves up to bit 1
  a_r7_hist_age: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[1] == $past(hist_q[0]));

endmodule

// File: rtl/bp2l_bank.sv
module bp2l_bank
  import bp2l_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr
);

  localparam int ENTRIES = 1 << IDX_W;

  ctr2_t ctr_q [ENTRIES];
  ctr2_t ctr_d [ENTRIES];
  logic  ent_en [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_comb begin
      ent_en[e] = wr_en && (wr_idx == IDX_W'(e));
      ctr_d[e]  = ctr_step(ctr_q[e], wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctr_q[e] <= CTR_WEAK_NT;
      else if (ent_en[e]) ctr_q[e] <= ctr_d[e];
    end

    // R4: strongly taken stays put on a taken outcome
    a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_en[e] && wr_taken && ctr_q[e] == CTR_STRONG_T) |=> ctr_q[e] == CTR_STRONG_T);

    // R5: strongly not-taken stays put on a not-taken outcome
    a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_en[e] && !wr_taken && ctr_q[e] == CTR_STRONG_NT) |=> ctr_q[e] == CTR_STRONG_NT);

    // R6: one wrong outcome from a strong state leaves the direction unchanged
    a_r6_hyst: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_en[e] && (ctr_q[e] == CTR_STRONG_T || ctr_q[e] == CTR_STRONG_NT))
        |=> ctr_q[e][1] == $past(ctr_q[e][1]));

    // R9: entries not addressed by a write keep their value
    a_r9_ent_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_en[e] |=> $stable(ctr_q[e]));
  end

  assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/bp2l_predictor.sv
module bp2l_predictor
  import bp2l_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int HIST_W     = 2,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [ADDR_W-1:0] lk_target,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken
);

  localparam int NUM_BANKS = 1 << HIST_W;
  localparam int OFF_W     = $clog2(INST_BYTES);
  localparam int IDX_LO    = OFF_W;
  localparam int IDX_HI    = OFF_W + IDX_W - 1;

  logic              rst_n_int;
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic              bank_wr [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_wr_vec;
  ctr2_t             bank_rd [NUM_BANKS];
  ctr2_t             lk_ctr;
  logic              unused_upd_bits;

  bp2l_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  bp2l_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist     (hist)
  );

  assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
  assign upd_idx = upd_pc[IDX_HI:IDX_LO];
  assign unused_upd_bits = ^{upd_pc[ADDR_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_wr[b]     = upd_valid && (hist == HIST_W'(b));
    assign bank_wr_vec[b] = bank_wr[b];

    bp2l_bank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .wr_en    (bank_wr[b]),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken),
      .rd_idx   (lk_idx),
      .rd_ctr   (bank_rd[b])
    );
  end

  always_comb begin
    lk_ctr     = bank_rd[hist];
    lk_taken   = ctr_dir(lk_ctr);
    lk_next_pc = lk_taken ? lk_target : lk_pc + ADDR_W'(INST_BYTES);
  end

  // R8: an update trains at most one bank
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(bank_wr_vec));

  // R8: a valid update always reaches some bank
  a_r8_some_bank: assert property (@(posedge clk) disable iff (!rst_n_int)
    upd_valid |-> $countones(bank_wr_vec) == 1);

  // R2: the prediction always returns one of the two candidate addresses
  a_r2_next_pick: assert property (@(posedge clk) disable iff (!rst_n_int)
    (lk_next_pc == lk_target) || (lk_next_pc == lk_pc + ADDR_W'(INST_BYTES)));

endmodule

// File: tb/bp2l_predictor_bench.sv
`timescale 1ns/1ps
module bp2l_predictor_bench;

  localparam int AW = 32;
  localparam int KW = 4;
  localparam int NE = 1 << KW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] lk_pc, lk_target, upd_pc, lk_next_pc;
  logic          lk_taken, upd_valid, upd_taken;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int model_ctr [4][NE];
  int model_hist;
  logic [31:0] seed = 32'h1badf00d;

  always #5 clk = ~clk;

  bp2l_predictor #(.ADDR_W(AW), .IDX_W(KW), .HIST_W(2), .INST_BYTES(4)) u_bp2l_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_target(lk_target),
    .lk_taken(lk_taken), .lk_next_pc(lk_next_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [AW-1:0] mk_pc(int idx);
    logic [31:0] r;
    r = rnd();
    return {r[31:KW+2], 4'(idx), r[1:0]};
  endfunction

  task automatic check_lookup(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input string tag);
    int idx;
    bit exp_t;
    logic [AW-1:0] exp_pc;
    lk_pc = pc;
    lk_target = tgt;
    #0.1;
    idx = int'((pc >> 2) & (NE - 1));
    exp_t = model_ctr[model_hist][idx] >= 2;
    exp_pc = exp_t ? tgt : pc + 4;
    checks++;
    if (lk_taken !== exp_t || lk_next_pc !== exp_pc) begin
      errors++;
      $display("FAIL %s pc=%h taken=%0b next=%h expected taken=%0b next=%h",
               tag, pc, lk_taken, lk_next_pc, exp_t, exp_pc);
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NE; i++) check_lookup(mk_pc(i), rnd(), tag);
  endtask

  task automatic model_update(input logic [AW-1:0] pc, input bit tk);
    int idx;
    idx = int'((pc >> 2) & (NE - 1));
    if (tk && model_ctr[model_hist][idx] < 3) model_ctr[model_hist][idx]++;
    if (!tk && model_ctr[model_hist][idx] > 0) model_ctr[model_hist][idx]--;
    model_hist = ((model_hist << 1) | int'(tk)) & 3;
  endtask

  // Drive one update; lookups before the edge must see the old state (R10).
  task automatic step(input bit v, input logic [AW-1:0] pc, input bit tk);
    @(negedge clk);
    upd_valid = v;
    upd_pc    = pc;
    upd_taken = tk;
    sweep("R10");
    @(posedge clk);
    if (v) model_update(pc, tk);
    #1;
    upd_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    lk_pc = '0; lk_target = '0;
    model_hist = 0;
    for (int b = 0; b < 4; b++) for (int i = 0; i < NE; i++) model_ctr[b][i] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    sweep("R1");

    // Saturation at the top, then the bottom, on one address (R4, R5)
    for (int n = 0; n < 7; n++) begin
      step(1'b1, mk_pc(0), 1'b1);
      @(negedge clk); sweep("R4");
    end
    for (int n = 0; n < 8; n++) begin
      step(1'b1, mk_pc(0), 1'b0);
      @(negedge clk); sweep("R5");
    end

    // Hysteresis from strong taken (R6)
    for (int n = 0; n < 5; n++) step(1'b1, mk_pc(3), 1'b1);
    step(1'b1, mk_pc(3), 1'b0);
    step(1'b1, mk_pc(9), 1'b1);
    step(1'b1, mk_pc(9), 1'b1);
    @(negedge clk); sweep("R6");
    check_lookup(mk_pc(3), 32'h0000_8000, "R6");

    // Hysteresis from strong not-taken (R6)
    for (int n = 0; n < 5; n++) step(1'b1, mk_pc(5), 1'b0);
    step(1'b1, mk_pc(5), 1'b1);
    step(1'b1, mk_pc(11), 1'b0);
    step(1'b1, mk_pc(11), 1'b0);
    @(negedge clk); sweep("R6");

    // Inputs with valid low are ignored (R9)
    for (int n = 0; n < 12; n++) begin
      step(1'b0, rnd(), rnd() % 2 == 1);
      @(negedge clk); sweep("R9");
    end

    // Random training: bank selection, index bits, history shift (R2 R3 R7 R8)
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = rnd();
      step(r[31:29] != 3'd0, mk_pc(int'(r[7:4]) % 6), r[12] | r[13]);
      @(negedge clk); sweep("R2 R3 R7 R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule